// File: doc/BRIEF.md
# Programmable Bus Clock-Enable Divider Tree

This block turns two fast source tick streams into four clock-enable pulse streams: a processor enable, a double-rate bus enable, an AHB enable and an APB enable. All of them live in one fast clock domain. Each source tick stands for one edge of a phase-locked loop output: one stream for the application loop and one for the memory loop. Every output is a single-cycle enable that downstream logic uses to advance. A 32-bit configuration word holds five ratio fields. Each divider produces one output pulse for every (field + 1) pulses of its parent.

The processor enable is divided from the application ticks. A mode input picks the parent of the bus branch. When the mode input is high (synchronous mode), the bus branch takes the application ticks directly. When it is low (asynchronous mode), it takes the memory ticks after the memory pre-divider. The double-rate bus enable divides that bus source. The AHB and APB enables each divide the double-rate bus enable. A newly written ratio is loaded into a divider only when that divider reaches the end of its current period, so no period is ever cut short.

Top module: `clkdiv_tree`

## Requirements
- R1: After reset the configuration word reads 0, so every ratio is 0 and each enable repeats its parent pulse for pulse.
- R2: The processor enable pulses once for every (bits [3:0] + 1) application ticks.
- R3: The double-rate bus enable pulses once for every (bits [11:9] + 1) bus-source pulses.
- R4: The AHB enable pulses once for every (bit [8] + 1) double-rate bus pulses.
- R5: The APB enable pulses once for every (bits [15:12] + 1) double-rate bus pulses.
- R6: With sync_mode_i = 1 the bus source is the application tick stream. With sync_mode_i = 0 it is the memory tick stream divided by (bit [4] + 1).
- R7: Each enable is high for single cycles only, and only in cycles in which its parent pulses.
- R8: A ratio written in the middle of a divider period takes effect only after that period completes at the old length.
- R9: Bits outside the mask 0x0000FF1F ignore writes and read as zero.
- R10: A write presented with cfg_we_i = 1 is visible on cfg_rdata_o from the next cycle onward.
- R11: With ratios 0, 1, 1 and 3 and a tick on every cycle, 400 cycles give 400 processor, 200 double-rate bus, 100 AHB and 50 APB pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| apll_tick_i | input | 1 | Application loop tick |
| mpll_tick_i | input | 1 | Memory loop tick |
| sync_mode_i | input | 1 | 1 = bus branch fed by application ticks, 0 = by memory branch |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| cpu_en_o | output | 1 | Processor clock enable |
| bus2x_en_o | output | 1 | Double-rate bus clock enable |
| ahb_en_o | output | 1 | AHB clock enable |
| apb_en_o | output | 1 | APB clock enable |

## Verification
The bench builds the tree with its default field widths: four-bit processor and APB ratios, a three-bit double-rate ratio and one-bit AHB and memory ratios. These widths let random writes reach every ratio value, including the 16-cycle APB step under a 256-tick bus chain. Random tick densities, mode flips and writes in the middle of a period exercise the deferred ratio load on every stage. Fixed-length windows, sized as a multiple of every period, check the exact pulse counts in both modes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int CFG_W     = 32;
    localparam int CPU_LSB   = 0;
    localparam int CPU_W     = 4;
    localparam int MEM_LSB   = 4;
    localparam int MEM_W     = 1;
    localparam int AHB_LSB   = 8;
    localparam int AHB_W     = 1;
    localparam int BUS2X_LSB = 9;
    localparam int BUS2X_W   = 3;
    localparam int APB_LSB   = 12;
    localparam int APB_W     = 4;

    function automatic logic [CFG_W-1:0] field_mask(int lsb, int w);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    localparam logic [CFG_W-1:0] CFG_MASK =
        field_mask(CPU_LSB, CPU_W)   | field_mask(MEM_LSB, MEM_W) |
        field_mask(AHB_LSB, AHB_W)   | field_mask(BUS2X_LSB, BUS2X_W) |
        field_mask(APB_LSB, APB_W);
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.word = wdata_i & CFG_MASK;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.word;

    // R9: undefined bits never hold a one
    a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o & ~CFG_MASK) == '0);

    // R10: a write shows on the read port one cycle later
    a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> rdata_o == ($past(wdata_i) & CFG_MASK));
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] ratio_i,
    output logic         en_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] ratio;
    } stage_t;

    stage_t st_d, st_q;
    logic   term;

    assign term = (st_q.cnt == st_q.ratio);
    assign en_o = tick_i & term;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (term) begin
                st_d.cnt   = '0;
                st_d.ratio = ratio_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: the count never passes the active ratio
    a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.ratio);

    // R8: the active ratio changes only at the end of a period
    a_r8_defer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |=> $stable(st_q.ratio));

    // R8: a period always restarts from zero
    a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> st_q.cnt == '0);
endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             apll_tick_i,
    input  logic             mpll_tick_i,
    input  logic             sync_mode_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    output logic             cpu_en_o,
    output logic             bus2x_en_o,
    output logic             ahb_en_o,
    output logic             apb_en_o
);
    logic mem_en;
    logic bus_tick;

    clkdiv_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o)
    );

    clkdiv_stage #(.W(CPU_W)) u_cpu (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (apll_tick_i),
        .ratio_i (cfg_rdata_o[CPU_LSB +: CPU_W]),
        .en_o    (cpu_en_o)
    );

    clkdiv_stage #(.W(MEM_W)) u_mem (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (mpll_tick_i),
        .ratio_i (cfg_rdata_o[MEM_LSB +: MEM_W]),
        .en_o    (mem_en)
    );

    // bus branch parent: application ticks in sync mode, memory branch otherwise
    assign bus_tick = sync_mode_i ? apll_tick_i : mem_en;

    clkdiv_stage #(.W(BUS2X_W)) u_bus2x (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (bus_tick),
        .ratio_i (cfg_rdata_o[BUS2X_LSB +: BUS2X_W]),
        .en_o    (bus2x_en_o)
    );

    clkdiv_stage #(.W(AHB_W)) u_ahb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (bus2x_en_o),
        .ratio_i (cfg_rdata_o[AHB_LSB +: AHB_W]),
        .en_o    (ahb_en_o)
    );

    clkdiv_stage #(.W(APB_W)) u_apb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (bus2x_en_o),
        .ratio_i (cfg_rdata_o[APB_LSB +: APB_W]),
        .en_o    (apb_en_o)
    );

    // R2: processor pulses fall on application ticks
    a_r2_cpu_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_en_o |-> apll_tick_i);

    // R4: AHB pulses fall on double-rate bus pulses
    a_r4_ahb_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ahb_en_o |-> bus2x_en_o);

    // R5: APB pulses fall on double-rate bus pulses
    a_r5_apb_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        apb_en_o |-> bus2x_en_o);

    // R6: in sync mode the bus branch follows the application ticks
    a_r6_sync_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_mode_i && bus2x_en_o) |-> apll_tick_i);

    // R6: in async mode the bus branch follows the memory ticks
    a_r6_async_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_mode_i && bus2x_en_o) |-> mpll_tick_i);
endmodule

// File: tb/clkdiv_tree_bench.sv
module clkdiv_tree_bench;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apll = 1'b0, mpll = 1'b0, sync = 1'b1, we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cpu_en, bus2x_en, ahb_en, apb_en;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // stage order: 0 processor, 1 memory, 2 double-rate bus, 3 AHB, 4 APB
    int lsb_t[5] = '{0, 4, 9, 8, 12};
    int wid_t[5] = '{4, 1, 3, 1, 4};
    int mcnt[5];
    int mrat[5];
    logic [31:0] mreg;
    int cnt_cpu, cnt_b2x, cnt_ahb, cnt_apb;

    always #(PERIOD/2) clk = ~clk;

    clkdiv_tree u_clkdiv_tree (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .apll_tick_i (apll),
        .mpll_tick_i (mpll),
        .sync_mode_i (sync),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .cpu_en_o    (cpu_en),
        .bus2x_en_o  (bus2x_en),
        .ahb_en_o    (ahb_en),
        .apb_en_o    (apb_en)
    );

    function automatic int fld(logic [31:0] v, int lsb, int w);
        return int'((v >> lsb) & ((32'd1 << w) - 1));
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin mcnt[i] = 0; mrat[i] = 0; end
        mreg = '0;
    endtask

    // one cycle: drive, compare against the model, then advance the model
    task automatic cyc(logic a, logic m, logic s, logic w, logic [31:0] d);
        bit tk[5];
        bit o[5];
        @(negedge clk);
        apll = a; mpll = m; sync = s; we = w; wdata = d;
        #1;
        tk[0] = a;        o[0] = tk[0] && (mcnt[0] == mrat[0]);
        tk[1] = m;        o[1] = tk[1] && (mcnt[1] == mrat[1]);
        tk[2] = s ? a : o[1];
        o[2] = tk[2] && (mcnt[2] == mrat[2]);
        tk[3] = o[2];     o[3] = tk[3] && (mcnt[3] == mrat[3]);
        tk[4] = o[2];     o[4] = tk[4] && (mcnt[4] == mrat[4]);
        check("R2 cpu_en", cpu_en, o[0]);
        check("R3/R6 bus2x_en", bus2x_en, o[2]);
        check("R4 ahb_en", ahb_en, o[3]);
        check("R5 apb_en", apb_en, o[4]);
        check("R10 rdata", rdata, mreg);
        if (bus2x_en && !(s ? a : m)) check("R7 bus2x parent", 1, 0);
        cnt_cpu += cpu_en; cnt_b2x += bus2x_en; cnt_ahb += ahb_en; cnt_apb += apb_en;
        for (int i = 0; i < 5; i++) begin
            if (tk[i]) begin
                if (o[i]) begin mcnt[i] = 0; mrat[i] = fld(mreg, lsb_t[i], wid_t[i]); end
                else mcnt[i]++;
            end
        end
        if (w) mreg = d & 32'h0000_FF1F;
    endtask

    task automatic clear_counts();
        cnt_cpu = 0; cnt_b2x = 0; cnt_ahb = 0; cnt_apb = 0;
    endtask

    initial begin
        int gap;
        int seen;
        void'($urandom(32'd5150));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all ratios zero, enables follow ticks
        cyc(1, 0, 1, 0, '0);
        check("R1 reset rdata", rdata, 0);
        check("R1 cpu follows tick", cpu_en, 1);
        check("R1 apb follows tick", apb_en, 1);

        // R11: ratio settings 0,1,1,3 in sync mode
        cyc(1, 1, 1, 1, 32'h0000_3310);
        repeat (300) cyc(1, 1, 1, 0, '0);
        clear_counts();
        repeat (400) cyc(1, 1, 1, 0, '0);
        check("R11 cpu count", cnt_cpu, 400);
        check("R11 bus2x count", cnt_b2x, 200);
        check("R11 ahb count", cnt_ahb, 100);
        check("R11 apb count", cnt_apb, 50);

        // R6: async mode, memory pre-divide by 2
        repeat (300) cyc(1, 1, 0, 0, '0);
        clear_counts();
        repeat (400) cyc(1, 1, 0, 0, '0);
        check("R6 async bus2x count", cnt_b2x, 100);
        check("R6 async ahb count", cnt_ahb, 50);
        check("R6 async apb count", cnt_apb, 25);
        check("R2 cpu unaffected by mode", cnt_cpu, 400);

        // R9: reserved bits ignore writes
        cyc(0, 0, 1, 1, 32'hFFFF_FFFF);
        cyc(0, 0, 1, 0, '0);
        check("R9 reserved bits", rdata, 32'h0000_FF1F);

        // R8: mid-period change waits for the period end
        cyc(1, 0, 1, 1, 32'h0000_0E00);
        repeat (40) cyc(1, 0, 1, 0, '0);
        seen = 0;
        for (int k = 0; k < 10 && !seen; k++) begin
            cyc(1, 0, 1, 0, '0);
            seen = bus2x_en;
        end
        check("R8 pulse found", seen, 1);
        cyc(1, 0, 1, 1, 32'h0000_0000);
        gap = 1;
        while (!bus2x_en && gap < 20) begin
            cyc(1, 0, 1, 0, '0);
            gap++;
        end
        check("R8 old period kept", gap, 8);
        cyc(1, 0, 1, 0, '0);
        check("R8 new ratio active", bus2x_en, 1);

        // random phase (R2..R7, R10 via the model)
        for (int k = 0; k < 20000; k++) begin
            logic a, m, s, w;
            a = ($urandom % 10) < 7;
            m = ($urandom % 10) < 4;
            s = (k / 1500) % 2 == 0;
            w = ($urandom % 40) == 0;
            cyc(a, m, s, w, $urandom);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule